// File: doc/BRIEF.md
# Staged-Expiry Watchdog Timer

This block is a memory-mapped watchdog that a processor must service at regular intervals. A small built-in tick timer divides an external 1 MHz tick-enable strobe into steps of programmable length. The watchdog counts those steps down from a configured period. Each time the countdown runs out, the block records an expiry and reloads the countdown. Only the fourth expiry in a row raises a system reset request. Expiries one to three can raise a level interrupt, which gives software a warning and a chance to recover first.

Software reaches the block through a simple word-addressed write port and a combinational read port. To service the watchdog, software writes the start command again: this reloads the countdown and clears the expiry history. The watchdog can only be stopped if a fixed key was written to a separate key register immediately before the stop command. This protects against a runaway program that happens to write the command register.

Top module: `stage_wdt`

## Requirements
- R1: After reset, the status word (0x24) and the configuration word (0x20) read 0, and both `irq` and `rst_req` are low.
- R2: The tick-timer load word at 0x00 has these fields: bit 31 is enable, bit 30 is periodic, and bits [23:0] are the reload value R. An enabled timer produces one step for every R strobes of `tick_en`. A non-periodic timer produces a single step and then clears bit 31 on readback. The word reads back as {running, periodic, 6'b0, R}.
- R3: The configuration word at 0x20 has these fields: bits [3:0] select the tick timer, bits [11:4] hold the period P (1..255), bit 12 is interrupt enable and bit 15 is reset enable. The countdown advances only when the select field equals 5.
- R4: The status word at 0x24 shows the countdown in bits [11:4] and the expiry count in bits [13:12]. Each step lowers the countdown by one. When the step arrives with the countdown at 1, that is an expiry: the countdown reloads to P and the expiry count goes up by one.
- R5: Writing 1 to bit 0 of the command word at 0x28 starts the watchdog, or restarts it if it is already running. The countdown becomes P, the expiry count becomes 0 and `irq` falls.
- R6: The fourth expiry halts the countdown and leaves the expiry count at 3 and the countdown at P. It raises `rst_req` only if reset enable is set. Expiries one to three never raise `rst_req`.
- R7: Once `rst_req` is high, it stays high through start commands and later activity until `rst_n` is asserted.
- R8: With interrupt enable set, expiries one to three drive `irq` high, and `irq` stays high until a start command clears it. With interrupt enable clear, `irq` stays low.
- R9: Writing 1 to bit 1 of the command word (with bit 0 at 0) halts the countdown only if the previous write to the key word at 0x2C was 0xC45A in bits [15:0]. Without that key the stop command has no effect.
- R10: Any write to the command word uses up the key. A key write of any value other than 0xC45A leaves the block locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | 1 MHz tick strobe, one clock wide |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt for early expiries |
| rst_req | output | 1 | Sticky system reset request |

## Verification
Suppose the countdown or the expiry count is wrong inside the block. The status word shows this at the next read. `irq` or `rst_req` then changes one step too early or too late, in the same clock cycle as the step that caused the expiry. A wrong key state only shows at the ports when a stop command follows. The countdown then either stays frozen or keeps falling, and the status read after one more step reveals it. A sticky-reset fault only shows when `rst_req` drops after a start command; if `rst_req` fails to drop after a real reset, that exposes the opposite fault.

// File: rtl/stage_wdt_pkg.sv
package stage_wdt_pkg;
  localparam int unsigned SEL_W    = 4;
  localparam int unsigned PERIOD_W = 8;
  localparam int unsigned EXP_W    = 2;
  localparam int unsigned KEY_W    = 16;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'hC45A;

  // word indices (byte address / 4)
  localparam int unsigned WORD_TMR = 0;
  localparam int unsigned WORD_CFG = 8;
  localparam int unsigned WORD_STS = 9;
  localparam int unsigned WORD_CMD = 10;
  localparam int unsigned WORD_KEY = 11;

  // field positions shared by configuration and status words
  localparam int unsigned FLD_LO     = 4;
  localparam int unsigned IRQ_EN_BIT = 12;
  localparam int unsigned RST_EN_BIT = 15;
  localparam int unsigned EXP_LO     = 12;
  localparam int unsigned CMD_START  = 0;
  localparam int unsigned CMD_STOP   = 1;

  typedef struct packed {
    logic                rst_en;
    logic                irq_en;
    logic [PERIOD_W-1:0] period;
    logic [SEL_W-1:0]    sel;
  } wdt_cfg_t;
endpackage

// File: rtl/stage_wdt_ticker.sv
module stage_wdt_ticker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TMR_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              load_we,
  input  logic [DATA_W-1:0] load_data,
  output logic              step,
  output logic [DATA_W-1:0] rd_val
);
  localparam int unsigned EN_BIT  = DATA_W - 1;
  localparam int unsigned PER_BIT = DATA_W - 2;

  logic             run_q, run_d;
  logic             per_q, per_d;
  logic [TMR_W-1:0] rel_q, rel_d;
  logic [TMR_W-1:0] cnt_q, cnt_d;

  logic unused_ticker;
  assign unused_ticker = ^load_data[PER_BIT-1:TMR_W];

  always_comb begin
    run_d = run_q;
    per_d = per_q;
    rel_d = rel_q;
    cnt_d = cnt_q;
    step  = 1'b0;
    if (load_we) begin
      run_d = load_data[EN_BIT];
      per_d = load_data[PER_BIT];
      rel_d = load_data[TMR_W-1:0];
      cnt_d = load_data[TMR_W-1:0];
    end else if (run_q && tick_en) begin
      if (cnt_q <= TMR_W'(1)) begin
        step  = 1'b1;
        cnt_d = rel_q;
        if (!per_q) run_d = 1'b0;
      end else begin
        cnt_d = cnt_q - TMR_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      per_q <= 1'b0;
      rel_q <= '0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      per_q <= per_d;
      rel_q <= rel_d;
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    rd_val             = '0;
    rd_val[EN_BIT]     = run_q;
    rd_val[PER_BIT]    = per_q;
    rd_val[TMR_W-1:0]  = rel_q;
  end

  assert_oneshot_halts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !per_q) |=> !run_q);
endmodule

// File: rtl/stage_wdt_regs.sv
module stage_wdt_regs
  import stage_wdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic [PERIOD_W-1:0] sts_cnt,
  input  logic [EXP_W-1:0]    sts_exp,
  input  logic [DATA_W-1:0]   tmr_rd,
  output wdt_cfg_t            cfg,
  output logic                tmr_we,
  output logic                start_cmd,
  output logic                stop_cmd,
  output logic [DATA_W-1:0]   bus_rdata
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              hit_cfg, hit_cmd, hit_key;
  wdt_cfg_t          cfg_q, cfg_d;
  logic              unl_q, unl_d;

  logic unused_regs;
  assign unused_regs = ^{bus_addr[1:0], bus_wdata[DATA_W-1:KEY_W]};

  assign word    = bus_addr[ADDR_W-1:2];
  assign tmr_we  = bus_wr && (word == WORD_W'(WORD_TMR));
  assign hit_cfg = bus_wr && (word == WORD_W'(WORD_CFG));
  assign hit_cmd = bus_wr && (word == WORD_W'(WORD_CMD));
  assign hit_key = bus_wr && (word == WORD_W'(WORD_KEY));

  // start wins when both command bits are written together
  assign start_cmd = hit_cmd && bus_wdata[CMD_START];
  assign stop_cmd  = hit_cmd && bus_wdata[CMD_STOP] && !bus_wdata[CMD_START] && unl_q;

  always_comb begin
    cfg_d = cfg_q;
    unl_d = unl_q;
    if (hit_cfg) begin
      cfg_d.sel    = bus_wdata[SEL_W-1:0];
      cfg_d.period = bus_wdata[FLD_LO +: PERIOD_W];
      cfg_d.irq_en = bus_wdata[IRQ_EN_BIT];
      cfg_d.rst_en = bus_wdata[RST_EN_BIT];
    end
    if (hit_key)      unl_d = (bus_wdata[KEY_W-1:0] == UNLOCK_KEY);
    else if (hit_cmd) unl_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      unl_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      unl_q <= unl_d;
    end
  end

  assign cfg = cfg_q;

  always_comb begin
    bus_rdata = '0;
    case (word)
      WORD_W'(WORD_TMR): bus_rdata = tmr_rd;
      WORD_W'(WORD_CFG): begin
        bus_rdata[SEL_W-1:0]           = cfg_q.sel;
        bus_rdata[FLD_LO +: PERIOD_W]  = cfg_q.period;
        bus_rdata[IRQ_EN_BIT]          = cfg_q.irq_en;
        bus_rdata[RST_EN_BIT]          = cfg_q.rst_en;
      end
      WORD_W'(WORD_STS): begin
        bus_rdata[FLD_LO +: PERIOD_W]  = sts_cnt;
        bus_rdata[EXP_LO +: EXP_W]     = sts_exp;
      end
      default: bus_rdata = '0;
    endcase
  end

  assert_key_spent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hit_cmd |=> !unl_q);
endmodule

// File: rtl/stage_wdt_core.sv
module stage_wdt_core
  import stage_wdt_pkg::*;
#(
  parameter int unsigned PAIR_ID = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_raw,
  input  wdt_cfg_t            cfg,
  input  logic                start_cmd,
  input  logic                stop_cmd,
  output logic [PERIOD_W-1:0] cnt,
  output logic [EXP_W-1:0]    exp_cnt,
  output logic                irq,
  output logic                rst_req
);
  logic                step;
  logic [PERIOD_W-1:0] per_eff;
  logic                run_q, run_d;
  logic [PERIOD_W-1:0] cnt_q, cnt_d;
  logic [EXP_W-1:0]    exp_q, exp_d;
  logic                irq_q, irq_d;
  logic                rst_q, rst_d;

  assign step    = step_raw && (cfg.sel == SEL_W'(PAIR_ID));
  assign per_eff = (cfg.period == '0) ? PERIOD_W'(1) : cfg.period;

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    exp_d = exp_q;
    irq_d = irq_q;
    rst_d = rst_q;
    if (start_cmd) begin
      run_d = 1'b1;
      cnt_d = per_eff;
      exp_d = '0;
      irq_d = 1'b0;
    end else if (stop_cmd) begin
      run_d = 1'b0;
    end else if (run_q && step) begin
      if (cnt_q <= PERIOD_W'(1)) begin
        cnt_d = per_eff;
        if (exp_q == '1) begin
          run_d = 1'b0;
          rst_d = rst_q | cfg.rst_en;
        end else begin
          exp_d = exp_q + EXP_W'(1);
          irq_d = irq_q | cfg.irq_en;
        end
      end else begin
        cnt_d = cnt_q - PERIOD_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      exp_q <= '0;
      irq_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
      exp_q <= exp_d;
      irq_q <= irq_d;
      rst_q <= rst_d;
    end
  end

  assign cnt     = cnt_q;
  assign exp_cnt = exp_q;
  assign irq     = irq_q;
  assign rst_req = rst_q;

  assert_rst_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> rst_q);
  assert_rst_on_fourth_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_q) |-> (exp_q == '1 && !run_q));
  assert_restart_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_cmd |=> (exp_q == '0 && !irq_q && run_q));
  assert_stop_halts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_cmd |=> !run_q);
  assert_count_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q != '0));
endmodule

// File: rtl/stage_wdt.sv
module stage_wdt
  import stage_wdt_pkg::*;
#(
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned TMR_W   = 24,
  parameter int unsigned PAIR_ID = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              rst_req
);
  logic [1:0]          rst_sync_q;
  logic                rst_int_n;
  logic                step_raw;
  logic [DATA_W-1:0]   tmr_rd;
  wdt_cfg_t            cfg;
  logic                tmr_we, start_cmd, stop_cmd;
  logic [PERIOD_W-1:0] cnt;
  logic [EXP_W-1:0]    exp_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  stage_wdt_ticker #(.DATA_W(DATA_W), .TMR_W(TMR_W)) u_ticker (
    .clk(clk), .rst_n(rst_int_n), .tick_en(tick_en),
    .load_we(tmr_we), .load_data(bus_wdata),
    .step(step_raw), .rd_val(tmr_rd));

  stage_wdt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .sts_cnt(cnt), .sts_exp(exp_cnt), .tmr_rd(tmr_rd),
    .cfg(cfg), .tmr_we(tmr_we), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
    .bus_rdata(bus_rdata));

  stage_wdt_core #(.PAIR_ID(PAIR_ID)) u_core (
    .clk(clk), .rst_n(rst_int_n), .step_raw(step_raw), .cfg(cfg),
    .start_cmd(start_cmd), .stop_cmd(stop_cmd),
    .cnt(cnt), .exp_cnt(exp_cnt), .irq(irq), .rst_req(rst_req));
endmodule

// File: tb/stage_wdt_bench.sv
`timescale 1ns/1ps
module stage_wdt_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en;
  logic        bus_wr;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq, rst_req;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  stage_wdt u_stage_wdt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .rst_req(rst_req));

  localparam logic [5:0] A_TMR = 6'h00, A_CFG = 6'h20, A_STS = 6'h24,
                         A_CMD = 6'h28, A_KEY = 6'h2C;

  // R, P, irq_en, rst_en, ticks, status, irq, rst_req
  localparam int VEC [0:5][0:7] = '{
    '{1, 3, 1, 1,  2, 32'h0010, 0, 0},
    '{2, 3, 1, 1,  7, 32'h1030, 1, 0},
    '{1, 2, 0, 1,  7, 32'h3010, 0, 0},
    '{1, 2, 1, 1,  8, 32'h3020, 1, 1},
    '{3, 1, 1, 0, 20, 32'h3010, 1, 0},
    '{1, 5, 0, 1, 12, 32'h2030, 0, 0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_wr = 1'b0; tick_en = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic setup(input int r, input int p, input int sel, input bit ie,
                       input bit re, input bit periodic);
    wr(A_TMR, {1'b1, periodic, 6'b0, 24'(r)});
    wr(A_CFG, 32'(sel) | (32'(p) << 4) | (32'(ie) << 12) | (32'(re) << 15));
    wr(A_CMD, 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog expired actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    rd_chk(A_STS, 32'h0, "R1 status after reset");
    rd_chk(A_CFG, 32'h0, "R1 config after reset");
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    chk("R1 rst_req after reset", {31'b0, rst_req}, 32'h0);

    // table walk: R4 countdown, R6 fourth expiry, R8 interrupt
    for (int i = 0; i < 6; i++) begin
      do_reset();
      setup(VEC[i][0], VEC[i][1], 5, VEC[i][2] != 0, VEC[i][3] != 0, 1'b1);
      ticks(VEC[i][4]);
      rd_chk(A_STS, 32'(VEC[i][5]), $sformatf("R4 status vector %0d", i));
      chk($sformatf("R8 irq vector %0d", i), {31'b0, irq}, 32'(VEC[i][6]));
      chk($sformatf("R6 rst_req vector %0d", i), {31'b0, rst_req}, 32'(VEC[i][7]));
    end

    // R5 restart mid countdown
    do_reset();
    setup(1, 4, 5, 1'b1, 1'b1, 1'b1);
    ticks(6);
    rd_chk(A_STS, 32'h1020, "R5 status before ping");
    chk("R8 irq before ping", {31'b0, irq}, 32'h1);
    wr(A_CMD, 32'h1);
    rd_chk(A_STS, 32'h0040, "R5 status after ping");
    chk("R5 irq cleared by ping", {31'b0, irq}, 32'h0);

    // R9 stop without key is ignored
    wr(A_CMD, 32'h2);
    ticks(2);
    rd_chk(A_STS, 32'h0020, "R9 stop without key ignored");
    // R9 stop with key halts
    wr(A_KEY, 32'h0000C45A);
    wr(A_CMD, 32'h2);
    ticks(3);
    rd_chk(A_STS, 32'h0020, "R9 stop with key freezes count");
    // R10 key consumed by an intervening ping
    wr(A_KEY, 32'h0000C45A);
    wr(A_CMD, 32'h1);
    wr(A_CMD, 32'h2);
    ticks(1);
    rd_chk(A_STS, 32'h0030, "R10 key spent by ping");
    // R10 wrong key value
    wr(A_KEY, 32'h00001234);
    wr(A_CMD, 32'h2);
    ticks(1);
    rd_chk(A_STS, 32'h0020, "R10 wrong key keeps lock");

    // R3 select mismatch: no countdown
    do_reset();
    setup(1, 3, 4, 1'b1, 1'b1, 1'b1);
    rd_chk(A_CFG, 32'h9034, "R3 config readback");
    ticks(10);
    rd_chk(A_STS, 32'h0030, "R3 other select does not count");

    // R2 one-shot tick timer
    do_reset();
    setup(2, 3, 5, 1'b0, 1'b1, 1'b0);
    rd_chk(A_TMR, 32'h80000002, "R2 timer readback running");
    ticks(10);
    rd_chk(A_STS, 32'h0020, "R2 one-shot gives one step");
    rd_chk(A_TMR, 32'h00000002, "R2 one-shot clears enable");

    // R6 / R7 sticky reset request
    do_reset();
    setup(1, 1, 5, 1'b0, 1'b1, 1'b1);
    ticks(3);
    chk("R6 no rst_req on third expiry", {31'b0, rst_req}, 32'h0);
    ticks(1);
    chk("R6 rst_req on fourth expiry", {31'b0, rst_req}, 32'h1);
    rd_chk(A_STS, 32'h3010, "R6 status after fourth expiry");
    wr(A_CMD, 32'h1);
    ticks(2);
    chk("R7 rst_req survives ping", {31'b0, rst_req}, 32'h1);
    do_reset();
    chk("R7 rst_req cleared by reset", {31'b0, rst_req}, 32'h0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule